// File: doc/BRIEF.md
# Frame Header Builder with Per-Frame Configuration Snapshot

This block supplies the opening bytes of each data frame streamed to a host over a byte-wide link. It keeps a 3-bit sub-frame enable mask that the host writes through a command channel. At the end of every frame it freezes that mask, the 3-bit stream-enable flags and a running frame number into one snapshot. The byte-output side can then read the header at its own pace while the live settings keep changing.

A byte index chooses which header byte is driven on the output, through a purely combinational path. The flags byte packs the snapshot mask and the stream flags, and its two top bits are held at zero. From that byte the host can tell which sub-frames were active in the frame it received, and it can reject a header whose reserved bits are set.

Top module: `frame_hdr_builder`

## Requirements
- R1: After reset the sub-frame mask is 3'b111 (bit2 = long, bit1 = medium, bit0 = short). The snapshot also resets to mask 3'b111, stream flags 3'b000 and frame number 0, so header byte 2 reads 0x38.
- R2: A command with cmd_valid high and cmd_opcode equal to 0x19 loads cmd_data[2:0] into the mask. Any other opcode, or cmd_valid low, leaves the mask unchanged.
- R3: The snapshot (mask, stream flags and frame number) changes only on a clock edge where frame_done is high. Changes to the mask or to stream_flags at any other time do not alter the header bytes.
- R4: Header byte 2 is {2'b00, snapshot mask[2:0], snapshot stream flags[2:0]}, with stream flag bit0 = range, bit1 = doppler and bit2 = cfar. With everything enabled it reads 0x3F.
- R5: Byte 0 is the marker parameter (default 0xA5) and byte 1 is the protocol version parameter (default 0x02).
- R6: Bytes 3 and 4 hold the 16-bit frame number, most significant byte first. The first completed frame after reset carries number 0, and each later frame carries the previous number plus one, wrapping from 0xFFFF to 0x0000.
- R7: Bytes 5 and 6 hold the range-bin count parameter (default 512), most significant byte first.
- R8: Bytes 7 and 8 hold the doppler-bin count parameter (default 48), most significant byte first.
- R9: Any byte index of 9 or more outputs 0x00.
- R10: When a mask write and frame_done occur on the same edge, the snapshot takes the mask value held before that edge. The new mask appears in the following frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Host command strobe |
| cmd_opcode | input | 8 | Host command opcode |
| cmd_data | input | 8 | Host command data; bits [2:0] used for the mask |
| stream_flags | input | 3 | Live stream-enable flags {cfar, doppler, range} |
| frame_done | input | 1 | Frame-complete pulse, one per frame |
| byte_idx | input | 4 | Header byte index to present |
| hdr_byte | output | 8 | Selected header byte |

## Verification
The flags byte is checked with several mask and stream-flag combinations: everything on, a sparse mask with a single stream, and everything off. These patterns show whether each field sits at its own bit position and whether the reserved bits stay at zero. Commands with the wrong opcode or with the strobe low must leave the mask untouched. A mask write on the same edge as a frame end shows whether the snapshot takes the old value or the new one. A long run of back-to-back frame ends drives the frame number through 0xFFFF and into its wrap, and the fixed bytes and out-of-range indices are read after reset and again after traffic.

// File: rtl/hdr_pkg.sv
package hdr_pkg;

    localparam int MASK_W = 3;
    localparam int FLAG_W = 3;
    localparam int FNUM_W = 16;
    localparam int BYTE_W = 8;

    typedef logic [MASK_W-1:0] mask_t;
    typedef logic [FLAG_W-1:0] flags_t;
    typedef logic [FNUM_W-1:0] fnum_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        mask_t  sf_mask;
        flags_t streams;
        fnum_t  fnum;
    } snap_t;

    localparam mask_t MASK_ALL = '1;

    localparam int POS_MARKER = 0;
    localparam int POS_VER    = 1;
    localparam int POS_FLAGS  = 2;
    localparam int POS_FN_HI  = 3;
    localparam int POS_FN_LO  = 4;
    localparam int POS_RB_HI  = 5;
    localparam int POS_RB_LO  = 6;
    localparam int POS_DB_HI  = 7;
    localparam int POS_DB_LO  = 8;
    localparam int HDR_LEN    = 9;

    localparam int RSVD_W = BYTE_W - MASK_W - FLAG_W;

    function automatic byte_t pack_flags(input mask_t m, input flags_t s);
        return {{RSVD_W{1'b0}}, m, s};
    endfunction

    function automatic byte_t hi_byte(input logic [15:0] v);
        return v[15:8];
    endfunction

    function automatic byte_t lo_byte(input logic [15:0] v);
        return v[7:0];
    endfunction

endpackage

// File: rtl/sf_mask_reg.sv
module sf_mask_reg
    import hdr_pkg::*;
#(
    parameter logic [7:0] MASK_OPCODE = 8'h19
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_opcode,
    input  mask_t      cmd_mask,
    output mask_t      mask_q
);

    logic wr_hit;
    assign wr_hit = cmd_valid && (cmd_opcode == MASK_OPCODE);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= MASK_ALL;
        end else if (wr_hit) begin
            mask_q <= cmd_mask;
        end
    end

    assert_mask_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && cmd_opcode == MASK_OPCODE) |=> $stable(mask_q));

    assert_mask_load_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_opcode == MASK_OPCODE) |=> mask_q == $past(cmd_mask));

endmodule

// File: rtl/frame_snapshot.sv
module frame_snapshot
    import hdr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   frame_done,
    input  mask_t  live_mask,
    input  flags_t live_flags,
    output snap_t  snap_q
);

    fnum_t fcount_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q.sf_mask <= MASK_ALL;
            snap_q.streams <= '0;
            snap_q.fnum    <= '0;
            fcount_q       <= '0;
        end else if (frame_done) begin
            snap_q.sf_mask <= live_mask;
            snap_q.streams <= live_flags;
            snap_q.fnum    <= fcount_q;
            fcount_q       <= fcount_q + fnum_t'(1);
        end
    end

    assert_snap_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !frame_done |=> $stable(snap_q));

    assert_count_step_R6: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> fcount_q == fnum_t'($past(fcount_q) + fnum_t'(1)));

    assert_snap_fnum_R6: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> snap_q.fnum == $past(fcount_q));

    assert_snap_mask_old_R10: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> snap_q.sf_mask == $past(live_mask));

endmodule

// File: rtl/hdr_byte_mux.sv
module hdr_byte_mux
    import hdr_pkg::*;
#(
    parameter int          IDX_W        = 4,
    parameter logic [7:0]  MARKER       = 8'hA5,
    parameter logic [7:0]  VERSION      = 8'h02,
    parameter logic [15:0] RANGE_BINS   = 16'd512,
    parameter logic [15:0] DOPPLER_BINS = 16'd48
) (
    input  snap_t            snap,
    input  logic [IDX_W-1:0] byte_idx,
    output byte_t            hdr_byte
);

    always_comb begin
        case (int'(byte_idx))
            POS_MARKER: hdr_byte = MARKER;
            POS_VER:    hdr_byte = VERSION;
            POS_FLAGS:  hdr_byte = pack_flags(snap.sf_mask, snap.streams);
            POS_FN_HI:  hdr_byte = hi_byte(snap.fnum);
            POS_FN_LO:  hdr_byte = lo_byte(snap.fnum);
            POS_RB_HI:  hdr_byte = hi_byte(RANGE_BINS);
            POS_RB_LO:  hdr_byte = lo_byte(RANGE_BINS);
            POS_DB_HI:  hdr_byte = hi_byte(DOPPLER_BINS);
            POS_DB_LO:  hdr_byte = lo_byte(DOPPLER_BINS);
            default:    hdr_byte = '0;
        endcase
    end

endmodule

// File: rtl/frame_hdr_builder.sv
module frame_hdr_builder
    import hdr_pkg::*;
#(
    parameter int          IDX_W        = 4,
    parameter logic [7:0]  MASK_OPCODE  = 8'h19,
    parameter logic [7:0]  MARKER       = 8'hA5,
    parameter logic [7:0]  VERSION      = 8'h02,
    parameter logic [15:0] RANGE_BINS   = 16'd512,
    parameter logic [15:0] DOPPLER_BINS = 16'd48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_opcode,
    input  logic [7:0]       cmd_data,
    input  logic [2:0]       stream_flags,
    input  logic             frame_done,
    input  logic [IDX_W-1:0] byte_idx,
    output logic [7:0]       hdr_byte
);

    mask_t live_mask;
    snap_t snap;
    logic  unused_cmd_hi;

    assign unused_cmd_hi = ^cmd_data[7:MASK_W];

    sf_mask_reg #(.MASK_OPCODE(MASK_OPCODE)) u_mask (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_opcode (cmd_opcode),
        .cmd_mask   (cmd_data[MASK_W-1:0]),
        .mask_q     (live_mask)
    );

    frame_snapshot u_snap (
        .clk        (clk),
        .rst        (rst),
        .frame_done (frame_done),
        .live_mask  (live_mask),
        .live_flags (stream_flags),
        .snap_q     (snap)
    );

    hdr_byte_mux #(
        .IDX_W        (IDX_W),
        .MARKER       (MARKER),
        .VERSION      (VERSION),
        .RANGE_BINS   (RANGE_BINS),
        .DOPPLER_BINS (DOPPLER_BINS)
    ) u_mux (
        .snap     (snap),
        .byte_idx (byte_idx),
        .hdr_byte (hdr_byte)
    );

    assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (int'(byte_idx) == POS_FLAGS) |-> hdr_byte[7:6] == 2'b00);

    assert_out_of_range_R9: assert property (@(posedge clk) disable iff (rst)
        (int'(byte_idx) >= HDR_LEN) |-> hdr_byte == 8'h00);

    assert_marker_R5: assert property (@(posedge clk) disable iff (rst)
        (int'(byte_idx) == POS_MARKER) |-> hdr_byte == MARKER);

endmodule

// File: tb/sim_frame_hdr_builder.sv
module sim_frame_hdr_builder;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_opcode = 8'h00;
    logic [7:0] cmd_data = 8'h00;
    logic [2:0] stream_flags = 3'b000;
    logic       frame_done = 1'b0;
    logic [3:0] byte_idx = 4'd0;
    logic [7:0] hdr_byte;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_hdr_builder u0 (
        .clk          (clk),
        .rst          (rst),
        .cmd_valid    (cmd_valid),
        .cmd_opcode   (cmd_opcode),
        .cmd_data     (cmd_data),
        .stream_flags (stream_flags),
        .frame_done   (frame_done),
        .byte_idx     (byte_idx),
        .hdr_byte     (hdr_byte)
    );

    typedef struct {
        logic [3:0] idx;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;

    // reference state kept by the bench
    logic [2:0]  m_mask  = 3'b111;
    logic [2:0]  s_mask  = 3'b111;
    logic [2:0]  s_flags = 3'b000;
    logic [15:0] s_fnum  = 16'd0;
    logic [15:0] m_count = 16'd0;

    function automatic logic [7:0] ref_byte(input int i);
        case (i)
            0: return 8'hA5;
            1: return 8'h02;
            2: return {2'b00, s_mask, s_flags};
            3: return s_fnum[15:8];
            4: return s_fnum[7:0];
            5: return 8'h02;
            6: return 8'h00;
            7: return 8'h00;
            8: return 8'h30;
            default: return 8'h00;
        endcase
    endfunction

    // monitor: compares away from the active edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (hdr_byte !== it.exp) begin
                errors++;
                $display("FAIL %s idx=%0d actual=0x%02h expected=0x%02h",
                         it.tag, it.idx, hdr_byte, it.exp);
            end
        end
    end

    task automatic check_byte(input int i, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        byte_idx = 4'(i);
        it.idx = 4'(i);
        it.exp = ref_byte(i);
        it.tag = tag;
        q.push_back(it);
        @(negedge clk);
        #1;
    endtask

    task automatic host_cmd(input logic [7:0] op, input logic [7:0] data, input logic vld);
        @(posedge clk);
        #1;
        cmd_valid = vld; cmd_opcode = op; cmd_data = data;
        @(posedge clk);
        if (vld && op == 8'h19) m_mask = data[2:0];
        #1;
        cmd_valid = 1'b0; cmd_opcode = 8'h00; cmd_data = 8'h00;
    endtask

    task automatic frames(input int n, input logic [2:0] fl);
        @(posedge clk);
        #1;
        frame_done = 1'b1; stream_flags = fl;
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            s_mask = m_mask; s_flags = fl; s_fnum = m_count; m_count = m_count + 16'd1;
        end
        #1;
        frame_done = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R1 / R4 / R5 / R6 / R7 / R8 reset contents
        check_byte(0, "R5 marker");
        check_byte(1, "R5 version");
        check_byte(2, "R1 reset flags 0x38");
        check_byte(3, "R6 reset fnum hi");
        check_byte(4, "R6 reset fnum lo");
        check_byte(5, "R7 range hi");
        check_byte(6, "R7 range lo");
        check_byte(7, "R8 doppler hi");
        check_byte(8, "R8 doppler lo");
        check_byte(9, "R9 idx 9");
        check_byte(15, "R9 idx 15");

        // R4 all enabled -> 0x3F
        frames(1, 3'b111);
        check_byte(2, "R4 all on 0x3F");
        check_byte(4, "R6 first frame number");

        // R2 write mask, R3 header unchanged until frame end
        host_cmd(8'h19, 8'hFD, 1'b1);
        stream_flags = 3'b000;
        check_byte(2, "R3 no change before frame end");
        frames(1, 3'b010);
        check_byte(2, "R4 sparse mask 0x2A");

        // R2 ignored commands
        host_cmd(8'h18, 8'h00, 1'b1);
        host_cmd(8'h19, 8'h00, 1'b0);
        frames(1, 3'b001);
        check_byte(2, "R2 ignored commands keep mask");
        check_byte(4, "R6 third frame number");

        // R10 simultaneous write and frame end
        @(posedge clk);
        #1;
        cmd_valid = 1'b1; cmd_opcode = 8'h19; cmd_data = 8'h00;
        frame_done = 1'b1; stream_flags = 3'b000;
        @(posedge clk);
        s_mask = m_mask; s_flags = 3'b000; s_fnum = m_count; m_count = m_count + 16'd1;
        m_mask = 3'b000;
        #1;
        cmd_valid = 1'b0; frame_done = 1'b0;
        check_byte(2, "R10 old mask in snapshot");
        frames(1, 3'b000);
        check_byte(2, "R10 new mask next frame");

        // R6 run to 0xFFFF and wrap
        frames(int'(16'hFFFF - m_count) + 1, 3'b100);
        check_byte(3, "R6 fnum hi at 0xFFFF");
        check_byte(4, "R6 fnum lo at 0xFFFF");
        frames(1, 3'b100);
        check_byte(3, "R6 wrap hi");
        check_byte(4, "R6 wrap lo");
        check_byte(2, "R4 cfar only");
        check_byte(0, "R5 marker after traffic");
        check_byte(12, "R9 idx 12 after traffic");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule